// File: doc/BRIEF.md
# Write-Leveling Sequencer

This block runs the strobe-to-clock alignment step of memory interface bring-up. On a start request it asks the command path to set the leveling-enable bit of the memory's mode register. It then works through the data strobe lanes one at a time. For the current lane it fires a strobe pulse and waits for the single feedback bit that the memory returns. That bit is the memory's clock as sampled by the strobe. The lane's delay tap then moves one step. The search stops when the feedback changes from 0 to 1 between neighbouring taps, and the tap at that change is kept for the lane.

A programmable wait separates every tap change from the next pulse, so that the delay line and the memory can settle. A lane whose tap reaches either end of its range without finding the change is marked failed, and the search moves on to the next lane. When every lane has been handled, the block clears the leveling-enable bit and raises `done` for one cycle. `error` is then high if any lane failed.

The delay line and the memory are outside the block. The block only drives tap codes and strobe requests and reads the returned bit.

Top module: `wrlvl_seq`

## Requirements
- R1: After `start`, the first request on the mode-register port carries `mr_sel`=1, `mr_bitpos`=7 and `mr_value`=1. `mr_req` and `mr_value` stay steady until `mr_ack`. No strobe pulse is issued while `mr_req` is high or before this first write is acknowledged.
- R2: Lanes are handled in ascending order, starting at lane 0. At most one bit of `dqs_pulse` is high in any cycle.
- R3: On `start`, and out of reset, every lane tap is `TAP_INIT` (default 32). After a returned 0 the tap rises by one. After a returned 1, when the lane has not yet seen a 0, the tap falls by one.
- R4: When a lane is searching upward, the first returned 1 at tap t locks the lane at t.
- R5: When a lane is searching downward, the first returned 0 at tap t locks the lane at t+1.
- R6: After a tap update, exactly `cfg_wait`+1 cycles pass in the wait before the next pulse. With feedback arriving k cycles after a pulse, successive pulses on one lane are k+`cfg_wait`+2 cycles apart.
- R7: A lane's tap does not change between its pulse and the feedback for that pulse.
- R8: A returned 0 at tap 2^`TAP_W`-1, or a returned 1 at tap 0 without a transition, fails the lane. The failed lane's `lane_fail` bit is set, its tap stays at that limit, and the sequence continues with the next lane.
- R9: After the last lane, a mode-register request with `mr_value`=0 (same `mr_sel` and `mr_bitpos`) is issued. After it is acknowledged, `done` is high for exactly one cycle. `error` is then the OR of `lane_fail` and holds until the next `start`.
- R10: `start` has no effect while a sequence is in progress. Exactly two mode-register writes are issued per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a leveling sequence (when idle) |
| cfg_wait | input | WAIT_W | Settle wait after each tap update, in cycles minus one |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | At least one lane failed in the last sequence |
| lane_fail | output | NUM_LANES | Per-lane failure flags |
| mr_req | output | 1 | Mode-register write request |
| mr_ack | input | 1 | Mode-register write accepted |
| mr_sel | output | 3 | Mode register index (1) |
| mr_bitpos | output | 4 | Bit position within the register (7) |
| mr_value | output | 1 | Value written to that bit |
| dqs_pulse | output | NUM_LANES | Strobe pulse request, one lane per cycle |
| fb_valid | input | NUM_LANES | Per-lane feedback strobe from the memory |
| fb_bit | input | NUM_LANES | Per-lane sampled-clock bit |
| tap_out | output | NUM_LANES*TAP_W | Per-lane delay tap codes, lane 0 in the low bits |

## Verification
Four properties are checked on every cycle: the pulse vector is one-hot or zero, mode-register requests stay steady until acknowledged with no pulse issued during them, taps stay steady from a pulse to the following cycle, and `done` lasts one cycle and comes with `error` whenever a lane failed. The remaining behaviour can only be seen through the bench's scenarios. That covers the direction of each tap step, the locked tap for upward and downward searches, failures at both tap limits, the exact pulse spacing for several wait settings, lane order, and a start request that arrives mid-run and is ignored.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MR_ON, ST_SETTLE, ST_PULSE,
    ST_SAMPLE, ST_NEXT, ST_MR_OFF, ST_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    ACT_UP, ACT_DOWN, ACT_LOCK, ACT_FAIL
  } step_act_t;
endpackage

// File: rtl/wrlvl_rst_sync.sv
module wrlvl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wrlvl_wait_timer.sv
module wrlvl_wait_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/wrlvl_step_logic.sv
module wrlvl_step_logic
  import wrlvl_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  logic [TAP_W-1:0] tap_cur,
  input  logic             fb,
  input  logic             seen,
  input  logic             dir_down,
  output step_act_t        act,
  output logic [TAP_W-1:0] tap_next,
  output logic             dir_next
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  logic at_max, at_min;
  assign at_max = (tap_cur == TAP_MAX);
  assign at_min = (tap_cur == '0);

  always_comb begin
    act      = ACT_FAIL;
    tap_next = tap_cur;
    dir_next = dir_down;
    if (seen && !dir_down && fb) begin
      act = ACT_LOCK;
    end else if (seen && dir_down && !fb) begin
      act      = ACT_LOCK;
      tap_next = tap_cur + 1'b1;
    end else if (!fb) begin
      dir_next = 1'b0;
      if (!at_max) begin
        act      = ACT_UP;
        tap_next = tap_cur + 1'b1;
      end
    end else begin
      dir_next = 1'b1;
      if (!at_min) begin
        act      = ACT_DOWN;
        tap_next = tap_cur - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrlvl_tap_bank.sv
module wrlvl_tap_bank #(
  parameter int NUM_LANES = 4,
  parameter int TAP_W     = 6,
  parameter int TAP_INIT  = 32,
  parameter int LANE_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init,
  input  logic                       wr_en,
  input  logic [LANE_W-1:0]          wr_lane,
  input  logic [TAP_W-1:0]           wr_data,
  output logic [NUM_LANES*TAP_W-1:0] taps
);
  localparam logic [TAP_W-1:0] INIT_CODE = TAP_W'(TAP_INIT);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic             sel;
    logic             en;
    logic [TAP_W-1:0] tap_q;
    assign sel = wr_en && (wr_lane == LANE_W'(g));
    assign en  = init | sel;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tap_q <= INIT_CODE;
      else if (en) tap_q <= init ? INIT_CODE : wr_data;
    end
    assign taps[g*TAP_W +: TAP_W] = tap_q;
  end
endmodule

// File: rtl/wrlvl_seq.sv
module wrlvl_seq
  import wrlvl_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int TAP_W     = 6,
  parameter int TAP_INIT  = 32,
  parameter int WAIT_W    = 8,
  parameter int MR_INDEX  = 1,
  parameter int MR_BIT    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [WAIT_W-1:0]          cfg_wait,
  output logic                       done,
  output logic                       error,
  output logic [NUM_LANES-1:0]       lane_fail,
  output logic                       mr_req,
  input  logic                       mr_ack,
  output logic [2:0]                 mr_sel,
  output logic [3:0]                 mr_bitpos,
  output logic                       mr_value,
  output logic [NUM_LANES-1:0]       dqs_pulse,
  input  logic [NUM_LANES-1:0]       fb_valid,
  input  logic [NUM_LANES-1:0]       fb_bit,
  output logic [NUM_LANES*TAP_W-1:0] tap_out
);
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  logic                 rst_n_s;
  seq_state_t           state_q, state_d;
  logic [LANE_W-1:0]    lane_q, lane_d;
  logic                 seen_q, seen_d, dir_q, dir_d;
  logic [NUM_LANES-1:0] fail_q, fail_d;
  logic                 err_q, err_d;
  logic                 tap_init, tap_we, tmr_load;
  logic [TAP_W-1:0]     tap_cur, tap_wdata, step_tap;
  logic                 step_dir;
  step_act_t            step_act;
  logic                 tmr_done;

  wrlvl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  wrlvl_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load),
    .run(state_q == ST_SETTLE), .load_val(cfg_wait), .expired(tmr_done)
  );

  wrlvl_tap_bank #(
    .NUM_LANES(NUM_LANES), .TAP_W(TAP_W), .TAP_INIT(TAP_INIT), .LANE_W(LANE_W)
  ) u_taps (
    .clk(clk), .rst_n(rst_n_s), .init(tap_init), .wr_en(tap_we),
    .wr_lane(lane_q), .wr_data(tap_wdata), .taps(tap_out)
  );

  assign tap_cur = tap_out[lane_q*TAP_W +: TAP_W];

  wrlvl_step_logic #(.TAP_W(TAP_W)) u_step (
    .tap_cur(tap_cur), .fb(fb_bit[lane_q]), .seen(seen_q), .dir_down(dir_q),
    .act(step_act), .tap_next(step_tap), .dir_next(step_dir)
  );

  assign tap_wdata = step_tap;

  always_comb begin
    state_d  = state_q;
    lane_d   = lane_q;
    seen_d   = seen_q;
    dir_d    = dir_q;
    fail_d   = fail_q;
    err_d    = err_q;
    tap_init = 1'b0;
    tap_we   = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_MR_ON;
        tap_init = 1'b1;
        fail_d   = '0;
        err_d    = 1'b0;
      end
      ST_MR_ON: if (mr_ack) begin
        state_d  = ST_SETTLE;
        lane_d   = '0;
        seen_d   = 1'b0;
        tmr_load = 1'b1;
      end
      ST_SETTLE: if (tmr_done) state_d = ST_PULSE;
      ST_PULSE:  state_d = ST_SAMPLE;
      ST_SAMPLE: if (fb_valid[lane_q]) begin
        unique case (step_act)
          ACT_UP, ACT_DOWN: begin
            tap_we   = 1'b1;
            seen_d   = 1'b1;
            dir_d    = step_dir;
            tmr_load = 1'b1;
            state_d  = ST_SETTLE;
          end
          ACT_LOCK: begin
            tap_we  = 1'b1;
            state_d = ST_NEXT;
          end
          default: begin
            fail_d[lane_q] = 1'b1;
            state_d        = ST_NEXT;
          end
        endcase
      end
      ST_NEXT: if (lane_q == LAST_LANE) begin
        state_d = ST_MR_OFF;
      end else begin
        lane_d   = lane_q + 1'b1;
        seen_d   = 1'b0;
        tmr_load = 1'b1;
        state_d  = ST_SETTLE;
      end
      ST_MR_OFF: if (mr_ack) begin
        err_d   = |fail_q;
        state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      seen_q  <= 1'b0;
      dir_q   <= 1'b0;
      fail_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      seen_q  <= seen_d;
      dir_q   <= dir_d;
      fail_q  <= fail_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    dqs_pulse = '0;
    if (state_q == ST_PULSE) dqs_pulse[lane_q] = 1'b1;
  end

  assign mr_req    = (state_q == ST_MR_ON) || (state_q == ST_MR_OFF);
  assign mr_value  = (state_q == ST_MR_ON);
  assign mr_sel    = 3'(MR_INDEX);
  assign mr_bitpos = 4'(MR_BIT);
  assign done      = (state_q == ST_FIN);
  assign error     = err_q;
  assign lane_fail = fail_q;
endmodule

// File: rtl/wrlvl_seq_chk.sv
module wrlvl_seq_chk #(
  parameter int NUM_LANES = 4,
  parameter int TAP_W     = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       done,
  input logic                       error,
  input logic [NUM_LANES-1:0]       lane_fail,
  input logic                       mr_req,
  input logic                       mr_ack,
  input logic                       mr_value,
  input logic [NUM_LANES-1:0]       dqs_pulse,
  input logic [NUM_LANES*TAP_W-1:0] tap_out
);
  assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dqs_pulse));

  assert_mr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_req && !mr_ack) |=> (mr_req && $stable(mr_value)));

  assert_no_pulse_in_mr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mr_req |-> (dqs_pulse == '0));

  assert_tap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_pulse != '0) |=> $stable(tap_out));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_gives_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (lane_fail != '0)) |-> error);
endmodule

bind wrlvl_seq wrlvl_seq_chk #(.NUM_LANES(NUM_LANES), .TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .error(error), .lane_fail(lane_fail),
  .mr_req(mr_req), .mr_ack(mr_ack), .mr_value(mr_value),
  .dqs_pulse(dqs_pulse), .tap_out(tap_out)
);

// File: tb/wrlvl_seq_test.sv
module wrlvl_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL         = 4;
  localparam int TW         = 6;
  localparam int TINIT      = 32;
  localparam int WW         = 8;
  localparam int FB_LAT     = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [WW-1:0] cfg_wait = '0;
  logic          done, error, mr_req, mr_value;
  logic          mr_ack = 1'b0;
  logic [2:0]    mr_sel;
  logic [3:0]    mr_bitpos;
  logic [NL-1:0] lane_fail, dqs_pulse;
  logic [NL-1:0] fb_valid = '0;
  logic [NL-1:0] fb_bit = '0;
  logic [NL*TW-1:0] tap_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int done_cnt = 0;
  int mr_seen_run = 0;
  int lane_edge [NL];
  int last_lane = -1;
  int last_cyc  = 0;
  int last_tap  = 0;
  int last_bit  = 0;

  int exp_mr [$];
  int exp_tap [$];
  int exp_fail [$];
  int exp_err [$];

  wrlvl_seq #(.NUM_LANES(NL), .TAP_W(TW), .TAP_INIT(TINIT), .WAIT_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_wait(cfg_wait),
    .done(done), .error(error), .lane_fail(lane_fail),
    .mr_req(mr_req), .mr_ack(mr_ack), .mr_sel(mr_sel), .mr_bitpos(mr_bitpos),
    .mr_value(mr_value), .dqs_pulse(dqs_pulse), .fb_valid(fb_valid),
    .fb_bit(fb_bit), .tap_out(tap_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tap_of(input int l);
    return int'(tap_out[l*TW +: TW]);
  endfunction

  // Mode-register responder and scoreboard pop
  initial begin
    forever begin
      @(negedge clk);
      if (mr_req) begin
        int e;
        mr_seen_run++;
        e = (exp_mr.size() > 0) ? exp_mr.pop_front() : -1;
        check(mr_value == e[0] && e >= 0, "R1 R9 mr value", int'(mr_value), e);
        check(mr_sel == 3'd1 && mr_bitpos == 4'd7, "R1 mr target",
              int'({mr_sel, mr_bitpos}), 8'h17);
        repeat (3) @(negedge clk);
        mr_ack = 1'b1;
        @(negedge clk);
        mr_ack = 1'b0;
      end
    end
  end

  // Memory model and pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (dqs_pulse != '0) begin
        int l, tp;
        l = 0;
        for (int i = 0; i < NL; i++) if (dqs_pulse[i]) l = i;
        tp = tap_of(l);
        if (last_lane == -1) begin
          check(l == 0, "R2 first lane", l, 0);
          check(tp == TINIT, "R3 initial tap", tp, TINIT);
          check(mr_seen_run == 1, "R1 pulse after entry write", mr_seen_run, 1);
        end else if (l == last_lane) begin
          check(cyc - last_cyc == FB_LAT + int'(cfg_wait) + 2, "R6 pulse spacing",
                cyc - last_cyc, FB_LAT + int'(cfg_wait) + 2);
          check(tp == last_tap + (last_bit != 0 ? -1 : 1), "R3 step direction",
                tp, last_tap + (last_bit != 0 ? -1 : 1));
        end else begin
          check(l == last_lane + 1, "R2 lane order", l, last_lane + 1);
          check(tp == TINIT, "R3 lane start tap", tp, TINIT);
        end
        last_lane = l;
        last_cyc  = cyc;
        last_tap  = tp;
        last_bit  = (tp >= lane_edge[l]) ? 1 : 0;
        repeat (FB_LAT) @(negedge clk);
        check(tap_of(l) == tp, "R7 tap steady until feedback", tap_of(l), tp);
        fb_bit[l]   = (last_bit != 0);
        fb_valid[l] = 1'b1;
        @(negedge clk);
        fb_valid = '0;
      end
    end
  end

  // Result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        for (int l = 0; l < NL; l++) begin
          int et, ef;
          et = exp_tap.pop_front();
          ef = exp_fail.pop_front();
          check(tap_of(l) == et, "R4 R5 R8 final tap", tap_of(l), et);
          check(int'(lane_fail[l]) == ef, "R8 lane flag", int'(lane_fail[l]), ef);
        end
        begin
          int ee;
          ee = exp_err.pop_front();
          check(int'(error) == ee, "R9 error", int'(error), ee);
        end
        @(negedge clk);
        check(!done, "R9 done one cycle", int'(done), 0);
        done_cnt++;
      end
    end
  end

  task automatic run_level(input int e0, input int e1, input int e2, input int e3,
                           input int wt, input bit restart_mid);
    int anyf;
    int target;
    lane_edge[0] = e0; lane_edge[1] = e1; lane_edge[2] = e2; lane_edge[3] = e3;
    cfg_wait = WW'(wt);
    anyf = 0;
    exp_mr.push_back(1);
    exp_mr.push_back(0);
    for (int l = 0; l < NL; l++) begin
      int e;
      e = lane_edge[l];
      if (e <= 0)              begin exp_tap.push_back(0);  exp_fail.push_back(1); anyf = 1; end
      else if (e >= (1 << TW)) begin exp_tap.push_back((1 << TW) - 1); exp_fail.push_back(1); anyf = 1; end
      else                     begin exp_tap.push_back(e);  exp_fail.push_back(0); end
    end
    exp_err.push_back(anyf);
    last_lane   = -1;
    mr_seen_run = 0;
    target      = done_cnt + 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart_mid) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
    check(mr_seen_run == 2, "R10 two mode writes per run", mr_seen_run, 2);
    check(int'(error) == anyf, "R9 error held after done", int'(error), anyf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !mr_req && !error, "R9 reset idle", int'({done, mr_req, error}), 0);
    check(dqs_pulse == '0, "R2 reset no pulse", int'(dqs_pulse), 0);
    check(tap_of(0) == TINIT && tap_of(3) == TINIT, "R3 reset taps", tap_of(0), TINIT);
    // Upward, downward, exact-at-start and one-above-start searches; mid-run start
    run_level(40, 20, 32, 33, 3, 1'b1);
    // Failures at both limits and locks at both ends of the range
    run_level(0, 64, 1, 63, 0, 1'b0);
    // Clean run after a failed one clears the error; longer wait
    run_level(45, 12, 50, 5, 7, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 3);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule